// File: doc/BRIEF.md
# Wake-Preamble START Sequencer

This block is the opening stage of an I2C master. When asked, it takes the bus with a START condition and shifts out a fixed wake-up byte whose seven leading zeros let a slow, polling receiver notice bus activity at a low sample rate. It then clocks a ninth slot with SDA released, and follows it with a repeated START that the polling receiver uses to synchronise. After that the bus is handed over, with SCL held LOW, to whatever logic sends the address byte.

Both bus lines are driven as open-drain pull-down enables: a 1 on an output pulls the line LOW, and a 0 releases it. The length of every SCL half-period is a number of system clocks taken from an input when the request is accepted. Any device that pulls SDA LOW during the ninth slot breaks the protocol, and the block reports it alongside the completion strobe.

Top module: `wake_preamble_gen`

## Requirements
- R1: After reset, `sclDrvLow`, `sdaDrvLow`, `done` and `ackErr` are all 0 (both lines released), and they stay that way until the first request.
- R2: A request accepted from rest produces a chain of phases. Each phase lasts one half-period. The first phase appears on the outputs one clock after the accepting edge. The chain is: setup (SCL and SDA released), START hold (SDA pulled, SCL released), nine bit slots of a low phase followed by a high phase (SCL pulled, then SCL released), repeated-START phases, then parking.
- R3: The eight data slots carry the byte 0000 0001 with the most significant bit first. SDA is pulled for a 0 bit and released for a 1 bit. The ninth slot keeps SDA released.
- R4: A half-period equals the `halfPeriod` value captured on the accepting edge. A value below 2 acts as 2. A change to `halfPeriod` during a frame has no effect on that frame.
- R5: Outside START conditions, SDA changes only while SCL is pulled and was already pulled the clock before. When SCL toggles at a phase boundary, SDA takes its new level one clock later. SDA is never released while SCL is released.
- R6: After the ninth slot, SCL is pulled for one half-period with SDA released. SCL is then released for one half-period. SDA is then pulled for one half-period while SCL stays released.
- R7: SDA is sampled on the last clock of the ninth high phase. If it is LOW, `ackErr` pulses together with `done`. Otherwise `ackErr` stays 0.
- R8: `done` is a one-clock pulse in the first cycle in which SCL is pulled after the repeated-START hold. From that cycle on, both outputs stay at 1 until the next request.
- R9: `startReq` is ignored while a frame is in progress.
- R10: A request accepted while parked first releases SDA with SCL still pulled for one half-period. The setup phase of R2 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a preamble frame, sampled while at rest |
| halfPeriod | input | DIV_W | SCL half-period in system clocks, captured at acceptance |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sclDrvLow | output | 1 | 1 pulls SCL LOW, 0 releases it |
| sdaDrvLow | output | 1 | 1 pulls SDA LOW, 0 releases it |
| done | output | 1 | One-clock pulse when the repeated START is complete |
| ackErr | output | 1 | Pulses with `done` when the ninth slot saw SDA LOW |

## Verification
The bench targets the single SDA release inside the byte (the step from bit six to bit seven). A design that moved SDA on the same clock as the falling SCL would show a data change while SCL is released. It also runs frames from both rest states, so a design that skipped the SDA release before a START from the parked state would never create a valid START edge. Frames with a half-period of zero and with `halfPeriod` changed mid-frame would show any design that reads the input live or fails to clamp it, because its phase lengths would drift against the model. Requests made during a frame, and a device that pulls SDA in the ninth slot, check that the frame cannot restart and that the error pulse lines up exactly with `done`.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int PRE_BITS = 8;
  localparam logic [PRE_BITS-1:0] PRE_VALUE = 8'b0000_0001;
  localparam int SLOT_COUNT = PRE_BITS + 1;
  localparam int IDX_W = $clog2(SLOT_COUNT);
  localparam int POS_W = $clog2(PRE_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_REL,
    ST_SETUP,
    ST_HOLD,
    ST_BLO,
    ST_BHI
  } wpgState_t;

  typedef struct packed {
    logic sclLow;
    logic sdaLow;
    logic accept;
    logic sampleAck;
    logic finish;
  } wpgStrobe_t;
endpackage

// File: rtl/wpg_ctrl.sv
module wpg_ctrl
  import wpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic       phaseEnd,
  output wpgStrobe_t strb
);
  wpgState_t stateQ;
  logic [IDX_W-1:0] bitIdxQ;
  logic repeatPassQ;
  logic isAckSlot;
  logic [POS_W-1:0] bitPos;
  logic slotBit;
  logic atRest;

  assign isAckSlot = (bitIdxQ == IDX_W'(PRE_BITS));
  assign bitPos = POS_W'(IDX_W'(PRE_BITS - 1) - bitIdxQ);
  assign slotBit = isAckSlot ? 1'b1 : PRE_VALUE[bitPos];
  assign atRest = (stateQ == ST_IDLE) || (stateQ == ST_PARK);

  always_comb begin
    strb = '0;
    case (stateQ)
      ST_PARK:  begin strb.sclLow = 1'b1; strb.sdaLow = 1'b1; end
      ST_REL:   begin strb.sclLow = 1'b1; strb.sdaLow = 1'b0; end
      ST_SETUP: begin strb.sclLow = 1'b0; strb.sdaLow = 1'b0; end
      ST_HOLD:  begin strb.sclLow = 1'b0; strb.sdaLow = 1'b1; end
      ST_BLO:   begin strb.sclLow = 1'b1; strb.sdaLow = ~slotBit; end
      ST_BHI:   begin strb.sclLow = 1'b0; strb.sdaLow = ~slotBit; end
      default:  begin strb.sclLow = 1'b0; strb.sdaLow = 1'b0; end
    endcase
    strb.accept = atRest && startReq;
    strb.sampleAck = (stateQ == ST_BHI) && isAckSlot && phaseEnd;
    strb.finish = (stateQ == ST_HOLD) && repeatPassQ && phaseEnd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      bitIdxQ <= '0;
      repeatPassQ <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE, ST_PARK: begin
          if (startReq) begin
            stateQ <= (stateQ == ST_IDLE) ? ST_SETUP : ST_REL;
            repeatPassQ <= 1'b0;
            bitIdxQ <= '0;
          end
        end
        ST_REL:   if (phaseEnd) stateQ <= ST_SETUP;
        ST_SETUP: if (phaseEnd) stateQ <= ST_HOLD;
        ST_HOLD: begin
          if (phaseEnd) begin
            stateQ <= repeatPassQ ? ST_PARK : ST_BLO;
            bitIdxQ <= '0;
          end
        end
        ST_BLO:   if (phaseEnd) stateQ <= ST_BHI;
        ST_BHI: begin
          if (phaseEnd) begin
            if (isAckSlot) begin
              stateQ <= ST_REL;
              repeatPassQ <= 1'b1;
            end else begin
              bitIdxQ <= bitIdxQ + IDX_W'(1);
              stateQ <= ST_BLO;
            end
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wpg_divider.sv
module wpg_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [DIV_W-1:0] halfPeriod,
  output logic             phaseEnd
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);
  logic [DIV_W-1:0] periodQ;
  logic [DIV_W-1:0] cntQ;
  logic [DIV_W-1:0] loadVal;

  assign loadVal = (halfPeriod < MIN_HALF) ? MIN_HALF : halfPeriod;
  assign phaseEnd = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      periodQ <= MIN_HALF;
      cntQ <= '0;
    end else if (accept) begin
      periodQ <= loadVal;
      cntQ <= loadVal - DIV_W'(1);
    end else if (cntQ == '0) begin
      cntQ <= periodQ - DIV_W'(1);
    end else begin
      cntQ <= cntQ - DIV_W'(1);
    end
  end
endmodule

// File: rtl/wpg_datapath.sv
module wpg_datapath
  import wpg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wpgStrobe_t       strb,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic             sdaIn,
  output logic             phaseEnd,
  output logic             sclDrvLow,
  output logic             sdaDrvLow,
  output logic             done,
  output logic             ackErr
);
  logic sclQ, sdaQ, ackSeenQ, finishQ, doneQ, errQ;

  wpg_divider #(.DIV_W(DIV_W)) u_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (strb.accept),
    .halfPeriod(halfPeriod),
    .phaseEnd  (phaseEnd)
  );

  // SDA follows only once SCL has settled, so data never moves on an SCL edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclQ <= 1'b0;
      sdaQ <= 1'b0;
    end else begin
      sclQ <= strb.sclLow;
      if (strb.sclLow == sclQ) sdaQ <= strb.sdaLow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ackSeenQ <= 1'b0;
      finishQ <= 1'b0;
      doneQ <= 1'b0;
      errQ <= 1'b0;
    end else begin
      if (strb.accept) ackSeenQ <= 1'b0;
      else if (strb.sampleAck && !sdaIn) ackSeenQ <= 1'b1;
      finishQ <= strb.finish;
      doneQ <= finishQ;
      errQ <= finishQ && ackSeenQ;
    end
  end

  assign sclDrvLow = sclQ;
  assign sdaDrvLow = sdaQ;
  assign done = doneQ;
  assign ackErr = errQ;
endmodule

// File: rtl/wake_preamble_gen.sv
module wake_preamble_gen
  import wpg_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic [DIV_W-1:0] halfPeriod,
  input  logic             sdaIn,
  output logic             sclDrvLow,
  output logic             sdaDrvLow,
  output logic             done,
  output logic             ackErr
);
  wpgStrobe_t strb;
  logic phaseEnd;

  wpg_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .startReq(startReq),
    .phaseEnd(phaseEnd),
    .strb    (strb)
  );

  wpg_datapath #(.DIV_W(DIV_W)) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .halfPeriod(halfPeriod),
    .sdaIn     (sdaIn),
    .phaseEnd  (phaseEnd),
    .sclDrvLow (sclDrvLow),
    .sdaDrvLow (sdaDrvLow),
    .done      (done),
    .ackErr    (ackErr)
  );
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker (
  input logic clk,
  input logic rst_n,
  input logic sclDrvLow,
  input logic sdaDrvLow,
  input logic done,
  input logic ackErr
);
  // R5: SDA released only while SCL is held low and was low before
  a_r5_release_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdaDrvLow) |-> (sclDrvLow && $past(sclDrvLow)));

  // R5: SDA never gets pulled on the same clock that SCL toggles
  a_r5_no_edge_collision: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdaDrvLow) |-> (sclDrvLow == $past(sclDrvLow)));

  // R8: completion is a single-clock pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion coincides with both lines held low
  a_r8_done_parked: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sclDrvLow && sdaDrvLow));

  // R7: protocol error only reported with completion
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ackErr |-> done);
endmodule

bind wake_preamble_gen wpg_checker u_wpgChecker (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclDrvLow(sclDrvLow),
  .sdaDrvLow(sdaDrvLow),
  .done     (done),
  .ackErr   (ackErr)
);

// File: tb/wake_preamble_gen_bench.sv
module wake_preamble_gen_bench;
  localparam int DIV_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startReq = 1'b0;
  logic [DIV_W-1:0] halfPeriod = '0;
  logic slavePull = 1'b0;
  logic sdaIn;
  logic sclDrvLow, sdaDrvLow, done, ackErr;

  int errors = 0;
  int checks = 0;
  logic finished = 1'b0;
  logic ignoreWin = 1'b0;
  logic hpWin = 1'b0;

  typedef struct packed {
    logic scl;
    logic sda;
    logic dn;
    logic err;
    logic ackw;
    logic [3:0] tag;
  } exp_t;

  exp_t expQ[$];
  logic restScl = 1'b0;
  logic restSda = 1'b0;
  logic prevScl = 1'b0;
  logic prevSda = 1'b0;

  always #4 clk = ~clk;

  assign sdaIn = !sdaDrvLow && !slavePull;

  wake_preamble_gen #(.DIV_W(DIV_W)) u_wake_preamble_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (startReq),
    .halfPeriod(halfPeriod),
    .sdaIn     (sdaIn),
    .sclDrvLow (sclDrvLow),
    .sdaDrvLow (sdaDrvLow),
    .done      (done),
    .ackErr    (ackErr)
  );

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd10: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic checkBit(input string req, input string what, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s%s%s %s actual=%0b expected=%0b at %0t", req,
               ignoreWin ? " R9" : "", hpWin ? " R4" : "", what, act, expv, $time);
    end
  endtask

  task automatic pushEntry(input logic scl, input logic sda, input logic dn, input logic err,
                           input logic ackw, input logic [3:0] tag);
    exp_t e;
    e.scl = scl; e.sda = sda; e.dn = dn; e.err = err; e.ackw = ackw; e.tag = tag;
    // R5: on an SCL toggle SDA keeps its old level for one clock
    if (scl != prevScl && sda != prevSda) begin
      e.sda = prevSda;
      e.tag = 4'd5;
    end
    prevScl = e.scl;
    prevSda = e.sda;
    expQ.push_back(e);
  endtask

  task automatic pushPhase(input logic scl, input logic sda, input int n, input logic ackw,
                           input logic [3:0] tag);
    for (int i = 0; i < n; i++) pushEntry(scl, sda, 1'b0, 1'b0, ackw, tag);
  endtask

  task automatic buildFrame(input int hp, input logic ack, input logic fromPark);
    int h;
    logic bitv;
    h = (hp < 2) ? 2 : hp;
    prevScl = restScl;
    prevSda = restSda;
    pushEntry(restScl, restSda, 1'b0, 1'b0, 1'b0, 4'd2);
    if (fromPark) begin
      pushPhase(1'b1, 1'b0, h, 1'b0, 4'd10);
      pushPhase(1'b0, 1'b0, h, 1'b0, 4'd10);
    end else begin
      pushPhase(1'b0, 1'b0, h, 1'b0, 4'd2);
    end
    pushPhase(1'b0, 1'b1, h, 1'b0, 4'd2);
    for (int b = 0; b < 8; b++) begin
      bitv = (b == 7);  // R3: byte 0000 0001, MSB first
      pushPhase(1'b1, !bitv, h, 1'b0, 4'd3);
      pushPhase(1'b0, !bitv, h, 1'b0, 4'd3);
    end
    pushPhase(1'b1, 1'b0, h, ack, 4'd7);
    pushPhase(1'b0, 1'b0, h, ack, 4'd7);
    pushPhase(1'b1, 1'b0, h, 1'b0, 4'd6);
    pushPhase(1'b0, 1'b0, h, 1'b0, 4'd6);
    pushPhase(1'b0, 1'b1, h, 1'b0, 4'd6);
    pushEntry(1'b1, 1'b1, 1'b1, ack, 1'b0, 4'd8);
    restScl = 1'b1;
    restSda = 1'b1;
  endtask

  task automatic step();
    exp_t e;
    @(negedge clk);
    if (expQ.size() > 0) e = expQ.pop_front();
    else begin
      e.scl = restScl; e.sda = restSda; e.dn = 1'b0; e.err = 1'b0; e.ackw = 1'b0;
      e.tag = restScl ? 4'd8 : 4'd1;
    end
    checkBit(tagName(e.tag), "sclDrvLow", sclDrvLow, e.scl);
    checkBit(tagName(e.tag), "sdaDrvLow", sdaDrvLow, e.sda);
    checkBit(e.dn ? "R8" : tagName(e.tag), "done", done, e.dn);
    checkBit(e.err ? "R7" : tagName(e.tag), "ackErr", ackErr, e.err);
    slavePull = e.ackw;
  endtask

  task automatic runFrame(input int hp, input logic ack, input logic poke, input logic hpCheck);
    int n;
    logic fromPark;
    fromPark = restScl;
    halfPeriod = DIV_W'(hp);
    hpWin = hpCheck;
    startReq = 1'b1;
    buildFrame(hp, ack, fromPark);
    step();
    startReq = 1'b0;
    n = 0;
    while (expQ.size() > 0) begin
      if (poke && n == 12) begin
        startReq = 1'b1;          // R9: request mid-frame must be ignored
        halfPeriod = DIV_W'(hp + 5);  // R4: mid-frame change has no effect
        ignoreWin = 1'b1;
      end else if (poke && n == 13) begin
        startReq = 1'b0;
      end
      step();
      n++;
    end
    ignoreWin = 1'b0;
    hpWin = 1'b0;
    repeat (4) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    checkBit("R1", "sclDrvLow in reset", sclDrvLow, 1'b0);
    checkBit("R1", "sdaDrvLow in reset", sdaDrvLow, 1'b0);
    checkBit("R1", "done in reset", done, 1'b0);
    rst_n = 1'b1;
    repeat (5) step();
    runFrame(3, 1'b0, 1'b0, 1'b0);
    runFrame(2, 1'b1, 1'b0, 1'b0);
    runFrame(0, 1'b0, 1'b1, 1'b1);
    runFrame(5, 1'b1, 1'b1, 1'b1);
    runFrame(4, 1'b0, 1'b0, 1'b0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule